// File: doc/BRIEF.md
# Register-Mapped PWM Timer Channel

This block is one pulse-width modulation channel controlled through a small 32-bit register bus. Software writes a period, a duty value and a control word. While the channel runs, an internal counter steps from zero up to period minus one and then wraps. The single output sits at the active level while the counter is below the duty value and at the inactive level for the rest of the period.

Period and duty writes go into shadow copies first. The shadow copies reach the working copies only when the channel is stopped or at a period boundary, so a running pulse is never cut short by a reprogramming. A build-time parameter picks one of two register layouts. The layouts differ in where period and duty sit, in which control bits start the channel, in whether the output levels can be chosen, and in the clock prescale factor.

Reads have no delay: `bus_rdata` follows `bus_addr` combinationally. Writes take effect at the rising clock edge where `bus_we` is high.

Top module: `pwm_timer_chan`

## Requirements
- R1: Word offsets decoded from `bus_addr[3:2]`. Offset 0x0 is the counter (read-only; writes are dropped) and 0xC is the control word. With `ALT_MAP=0`, 0x4 holds the period and 0x8 the duty. With `ALT_MAP=1` the two swap: 0x4 is duty and 0x8 is period. Reads of period and duty return the last value written.
- R2: With `ALT_MAP=0` the channel runs only when control bits 0 and 1 are both 1. With `ALT_MAP=1` it runs only when control bits 0 and 3 are both 1.
- R3: While running with a nonzero period, the counter goes 0,1,…,period-1 and then back to 0. The output is active while counter < duty and inactive otherwise.
- R4: With `ALT_MAP=0`, control bit 3 sets the active level (1 = high) and control bit 4 sets the inactive and idle level (1 = high). With `ALT_MAP=1` the active level is always high, the inactive level is always low, and bits 3 and 4 have no level meaning.
- R5: A duty greater than or equal to a nonzero period keeps the output at the active level. A period of zero keeps it at the inactive level.
- R6: While stopped, the output is at the idle level. From the second cycle after stopping, the counter reads zero.
- R7: While running, a new period or duty takes effect only from the next period boundary.
- R8: The counter advances once every clock with `ALT_MAP=0` and once every two clocks with `ALT_MAP=1`.
- R9: The counter value can be read at any time through offset 0x0.
- R10: After reset every register reads zero and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational on `bus_addr` |
| pwm_out | output | 1 | PWM output |

## Verification
A write lands at the rising edge where `bus_we` is high. A control write that starts the channel gives counter 0, with the output at its level for count 0, right after that edge; the bench samples that at the next falling edge and counts one sample per clock from there. A control write that stops the channel moves the output to the idle level after that same edge, but the counter clears only one edge later, so the bench reads the counter one clock after it checks the output. Reads are combinational, so the bench sets the address just after a falling edge and samples a nanosecond later, well before the next rising edge.

// File: rtl/pwm_chan_pkg.sv
// Package: shared types and address decode for the PWM timer channel.
// Assumes word-aligned register offsets decoded from address bits [3:2].
package pwm_chan_pkg;

    typedef enum logic [1:0] {
        SEL_CNT    = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_DUTY   = 2'd2,
        SEL_CTRL   = 2'd3
    } reg_sel_e;

    // Map a word index to a register; the alternate map swaps period and duty.
    function automatic reg_sel_e word_to_sel(input logic [1:0] word, input logic alt_map);
        reg_sel_e sel;
        unique case (word)
            2'd0:    sel = SEL_CNT;
            2'd1:    sel = alt_map ? SEL_DUTY : SEL_PERIOD;
            2'd2:    sel = alt_map ? SEL_PERIOD : SEL_DUTY;
            default: sel = SEL_CTRL;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/pwm_regfile.sv
// Register file: holds shadow period, shadow duty and control word, and
// muxes read data. The counter is read-only here; its value comes from the core.
// Assumes ADDR_W >= 4; address bits above 3 must be zero for a hit.
module pwm_regfile
    import pwm_chan_pkg::*;
#(
    parameter int ALT_MAP = 0,
    parameter int DW      = 32,
    parameter int ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic [DW-1:0]     cnt_val,
    output logic [DW-1:0]     shd_period,
    output logic [DW-1:0]     shd_duty,
    output logic [DW-1:0]     ctrl,
    output logic [DW-1:0]     rdata
);

    logic     hit;
    reg_sel_e sel;
    logic     unused_byte_bits;

    assign unused_byte_bits = ^addr[1:0];

    generate
        if (ADDR_W > 4) begin : g_upper
            assign hit = (addr[ADDR_W-1:4] == '0);
        end else begin : g_exact
            assign hit = 1'b1;
        end
    endgenerate

    // Select the addressed register from the word index.
    always_comb sel = word_to_sel(addr[3:2], ALT_MAP != 0);

    // Capture bus writes into the shadow and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_period <= '0;
            shd_duty   <= '0;
            ctrl       <= '0;
        end else if (we && hit) begin
            unique case (sel)
                SEL_PERIOD: shd_period <= wdata;
                SEL_DUTY:   shd_duty   <= wdata;
                SEL_CTRL:   ctrl       <= wdata;
                default:    ;
            endcase
        end
    end

    // Return the addressed register, zero when the address misses.
    always_comb begin
        rdata = '0;
        if (hit) begin
            unique case (sel)
                SEL_CNT:    rdata = cnt_val;
                SEL_PERIOD: rdata = shd_period;
                SEL_DUTY:   rdata = shd_duty;
                default:    rdata = ctrl;
            endcase
        end
    end

endmodule

// File: rtl/pwm_ctrl_decode.sv
// Control decode: turns the control word into run, active level and idle
// level for the chosen register map. Pure combinational.
module pwm_ctrl_decode #(
    parameter int ALT_MAP = 0,
    parameter int DW      = 32
) (
    input  logic [DW-1:0] ctrl,
    output logic          run,
    output logic          act_lvl,
    output logic          idle_lvl
);

    logic unused_ctrl_bits;

    generate
        if (ALT_MAP == 0) begin : g_main_map
            // Run needs enable and continuous; levels are programmable.
            always_comb begin
                run      = ctrl[0] & ctrl[1];
                act_lvl  = ctrl[3];
                idle_lvl = ctrl[4];
            end
            assign unused_ctrl_bits = ^{ctrl[DW-1:5], ctrl[2]};
        end else begin : g_alt_map
            // Run needs timer enable and output enable; levels are fixed.
            always_comb begin
                run      = ctrl[0] & ctrl[3];
                act_lvl  = 1'b1;
                idle_lvl = 1'b0;
            end
            assign unused_ctrl_bits = ^{ctrl[DW-1:4], ctrl[2:1]};
        end
    endgenerate

endmodule

// File: rtl/pwm_prescaler.sv
// Prescaler: emits a one-cycle tick every PRE clocks while running, and is
// held at zero while stopped, so the first tick comes PRE-1 clocks after start.
module pwm_prescaler #(
    parameter int PRE = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int PW = (PRE > 1) ? $clog2(PRE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRE - 1);

    logic [PW-1:0] div_q;

    // Count clocks modulo PRE while running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || div_q == LAST) div_q <= '0;
        else                                 div_q <= div_q + PW'(1);
    end

    assign tick = run && (div_q == LAST);

endmodule

// File: rtl/pwm_core.sv
// Counter core: working period/duty registers, the period counter and the
// compare that forms the output. Working registers reload from the shadows
// while stopped and at every period boundary.
module pwm_core #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic [DW-1:0] shd_period,
    input  logic [DW-1:0] shd_duty,
    input  logic          act_lvl,
    input  logic          idle_lvl,
    output logic [DW-1:0] cnt,
    output logic [DW-1:0] work_period,
    output logic [DW-1:0] work_duty,
    output logic          pwm_out
);

    logic wrap;
    logic reload;

    assign wrap   = (work_period == '0) || (cnt >= work_period - DW'(1));
    assign reload = !run || (tick && wrap);

    // Step the counter on each tick, wrap at period-1, hold zero when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= wrap ? '0 : cnt + DW'(1);
    end

    // Reload working period and duty from the shadows at a safe point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_period <= '0;
            work_duty   <= '0;
        end else if (reload) begin
            work_period <= shd_period;
            work_duty   <= shd_duty;
        end
    end

    // Drive the active level while the count is below duty.
    always_comb begin
        if (!run || work_period == '0) pwm_out = idle_lvl;
        else if (cnt < work_duty)      pwm_out = act_lvl;
        else                           pwm_out = idle_lvl;
    end

endmodule

// File: rtl/pwm_timer_chan.sv
// Top: single PWM timer channel behind a word register bus. ALT_MAP picks the
// register layout and prescale factor (0: factor 1, 1: factor 2).
module pwm_timer_chan #(
    parameter int ALT_MAP = 0,
    parameter int DW      = 32,
    parameter int ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              pwm_out
);

    localparam int PRE = (ALT_MAP == 0) ? 1 : 2;

    logic [DW-1:0] shd_period;
    logic [DW-1:0] shd_duty;
    logic [DW-1:0] ctrl;
    logic [DW-1:0] cnt_val;
    logic [DW-1:0] work_period;
    logic [DW-1:0] work_duty;
    logic          run;
    logic          act_lvl;
    logic          idle_lvl;
    logic          tick;

    pwm_regfile #(.ALT_MAP(ALT_MAP), .DW(DW), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (bus_we),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .cnt_val    (cnt_val),
        .shd_period (shd_period),
        .shd_duty   (shd_duty),
        .ctrl       (ctrl),
        .rdata      (bus_rdata)
    );

    pwm_ctrl_decode #(.ALT_MAP(ALT_MAP), .DW(DW)) u_dec (
        .ctrl     (ctrl),
        .run      (run),
        .act_lvl  (act_lvl),
        .idle_lvl (idle_lvl)
    );

    pwm_prescaler #(.PRE(PRE)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    pwm_core #(.DW(DW)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .tick        (tick),
        .shd_period  (shd_period),
        .shd_duty    (shd_duty),
        .act_lvl     (act_lvl),
        .idle_lvl    (idle_lvl),
        .cnt         (cnt_val),
        .work_period (work_period),
        .work_duty   (work_duty),
        .pwm_out     (pwm_out)
    );

endmodule

// File: rtl/pwm_timer_chan_chk.sv
// Checker: temporal properties of the PWM channel, bound into the top.
module pwm_timer_chan_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          act_lvl,
    input logic          idle_lvl,
    input logic [DW-1:0] cnt,
    input logic [DW-1:0] work_period,
    input logic [DW-1:0] work_duty,
    input logic          pwm_out
);

    // R6
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> pwm_out == idle_lvl);

    // R6
    idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && $past(!run)) |-> cnt == '0);

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && work_period != '0) |-> cnt < work_period);

    // R5
    duty_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && work_period != '0 && work_duty >= work_period) |-> pwm_out == act_lvl);

    // R5
    zero_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && work_period == '0) |-> pwm_out == idle_lvl);

    // R7
    work_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && cnt != '0) |-> ($stable(work_period) && $stable(work_duty)));

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> (cnt == '0 || cnt == $past(cnt) || cnt == $past(cnt) + DW'(1)));

endmodule

bind pwm_timer_chan pwm_timer_chan_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .act_lvl     (act_lvl),
    .idle_lvl    (idle_lvl),
    .cnt         (cnt_val),
    .work_period (work_period),
    .work_duty   (work_duty),
    .pwm_out     (pwm_out)
);

// File: tb/pwm_timer_chan_bench.sv
module pwm_timer_chan_bench;

    typedef struct packed {
        logic [31:0] per;
        logic [31:0] duty;
        logic        pol;
        logic        idle;
        logic [7:0]  len;
        logic [7:0]  hi;
    } vec_t;

    // Main map: period, duty, active-high bit, idle-high bit, window, high cycles.
    localparam vec_t VECS [8] = '{
        '{32'd8, 32'd3, 1'b1, 1'b0, 8'd8, 8'd3},
        '{32'd8, 32'd3, 1'b0, 1'b1, 8'd8, 8'd5},
        '{32'd5, 32'd5, 1'b1, 1'b0, 8'd5, 8'd5},
        '{32'd5, 32'd9, 1'b1, 1'b0, 8'd5, 8'd5},
        '{32'd6, 32'd0, 1'b1, 1'b0, 8'd6, 8'd0},
        '{32'd0, 32'd4, 1'b1, 1'b0, 8'd4, 8'd0},
        '{32'd0, 32'd4, 1'b0, 1'b1, 8'd4, 8'd4},
        '{32'd4, 32'd1, 1'b1, 1'b1, 8'd4, 8'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        we_a, we_b;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] rdata_a, rdata_b;
    logic        out_a, out_b;
    int          total = 0;
    int          bad = 0;

    always #10 clk = ~clk;

    pwm_timer_chan #(.ALT_MAP(0)) u_pwm_timer_chan (
        .clk(clk), .rst_n(rst_n), .bus_we(we_a), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .pwm_out(out_a));

    pwm_timer_chan #(.ALT_MAP(1)) u_alt (
        .clk(clk), .rst_n(rst_n), .bus_we(we_b), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .pwm_out(out_b));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called just after a falling edge; the write lands at the next rising edge.
    task automatic wr(input bit alt, input logic [3:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        if (alt) we_b = 1'b1; else we_a = 1'b1;
        @(negedge clk);
        we_a = 1'b0;
        we_b = 1'b0;
    endtask

    task automatic rd(input bit alt, input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = alt ? rdata_b : rdata_a;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] ctl;
        int          hi;
        rst_n = 1'b0; we_a = 1'b0; we_b = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state of both layouts
        check("R10 out main", {31'd0, out_a}, 32'd0);
        check("R10 out alt", {31'd0, out_b}, 32'd0);
        for (int k = 0; k < 4; k++) begin
            rd(0, 4'(k * 4), d); check("R10 reg main", d, 32'd0);
            rd(1, 4'(k * 4), d); check("R10 reg alt", d, 32'd0);
        end

        // R1: main-map readback of period and duty
        wr(0, 4'h4, 32'h1234_5678);
        wr(0, 4'h8, 32'h0000_00AB);
        rd(0, 4'h4, d); check("R1 period readback", d, 32'h1234_5678);
        rd(0, 4'h8, d); check("R1 duty readback", d, 32'h0000_00AB);

        // R3 R4 R5 R6: vector table on the main map
        for (int v = 0; v < 8; v++) begin
            wr(0, 4'h4, VECS[v].per);
            wr(0, 4'h8, VECS[v].duty);
            ctl = 32'h3 | (32'(VECS[v].pol) << 3) | (32'(VECS[v].idle) << 4);
            wr(0, 4'hC, ctl);
            hi = 0;
            for (int j = 0; j < int'(VECS[v].len); j++) begin
                if (out_a) hi++;
                @(negedge clk);
            end
            check($sformatf("R3 R4 R5 high cycles vec %0d", v), 32'(hi), 32'(VECS[v].hi));
            wr(0, 4'hC, ctl & ~32'h3);
            check($sformatf("R6 idle level vec %0d", v), {31'd0, out_a}, {31'd0, VECS[v].idle});
            @(negedge clk);
            rd(0, 4'h0, d); check($sformatf("R6 counter zero vec %0d", v), d, 32'd0);
        end

        // R2: main map does not run without the continuous bit, nor without enable
        wr(0, 4'h4, 32'd4);
        wr(0, 4'h8, 32'd2);
        wr(0, 4'hC, 32'h09);
        hi = 0;
        for (int j = 0; j < 4; j++) begin if (out_a) hi++; @(negedge clk); end
        check("R2 no continuous bit, output", 32'(hi), 32'd0);
        rd(0, 4'h0, d); check("R2 no continuous bit, counter", d, 32'd0);
        wr(0, 4'hC, 32'h0A);
        @(negedge clk);
        rd(0, 4'h0, d); check("R2 no enable bit, counter", d, 32'd0);
        check("R2 no enable bit, output", {31'd0, out_a}, 32'd0);

        // R9: counter readback while running; writes to offset 0 are dropped
        wr(0, 4'h4, 32'd10);
        wr(0, 4'h8, 32'd0);
        wr(0, 4'hC, 32'h03);
        rd(0, 4'h0, d); check("R9 counter at start", d, 32'd0);
        repeat (7) @(negedge clk);
        rd(0, 4'h0, d); check("R9 counter after 7", d, 32'd7);
        wr(0, 4'h0, 32'd5);
        rd(0, 4'h0, d); check("R9 counter write dropped", d, 32'd8);
        wr(0, 4'hC, 32'h0);
        @(negedge clk);

        // R7: duty change mid-period waits for the boundary
        wr(0, 4'h4, 32'd8);
        wr(0, 4'h8, 32'd2);
        wr(0, 4'hC, 32'h0B);
        repeat (3) @(negedge clk);
        wr(0, 4'h8, 32'd6);
        check("R7 old duty still applies", {31'd0, out_a}, 32'd0);
        hi = 0;
        for (int j = 4; j < 16; j++) begin if (out_a) hi++; @(negedge clk); end
        check("R7 new duty from boundary", 32'(hi), 32'd6);
        wr(0, 4'hC, 32'h0);

        // R1: alternate map swaps period and duty offsets
        wr(1, 4'h4, 32'd1);
        wr(1, 4'h8, 32'd4);
        rd(1, 4'h4, d); check("R1 alt duty readback", d, 32'd1);
        rd(1, 4'h8, d); check("R1 alt period readback", d, 32'd4);

        // R2: alternate map ignores the continuous bit as a run condition
        wr(1, 4'hC, 32'h03);
        hi = 0;
        for (int j = 0; j < 4; j++) begin if (out_b) hi++; @(negedge clk); end
        check("R2 alt bits 0,1 do not run", 32'(hi), 32'd0);
        rd(1, 4'h0, d); check("R2 alt counter idle", d, 32'd0);

        // R8 R4: alternate runs at half rate, active-high regardless of bit 4
        wr(1, 4'hC, 32'h19);
        hi = 0;
        for (int j = 0; j < 8; j++) begin
            if (j == 5) begin
                rd(1, 4'h0, d); check("R8 alt counter half rate", d, 32'd2);
            end
            if (out_b) hi++;
            @(negedge clk);
        end
        check("R8 R4 alt high cycles", 32'(hi), 32'd2);
        wr(1, 4'hC, 32'h10);
        check("R4 alt idle stays low", {31'd0, out_b}, 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule